// File: doc/BRIEF.md
# Branch Direction and Target Predictor

This block predicts, for a relative branch, whether it will be taken and where it goes. A lookup names a branch by its instruction address. It also gives a flag telling whether the branch is conditional, and the signed byte offset encoded in it. One cycle later the block returns a taken/not-taken guess and a target address. Behind the lookup sits a direct-mapped history table indexed by instruction address. Each entry keeps a valid bit, an address tag, the last resolved target and a two-bit saturating direction state.

When the table has no matching entry, a fixed rule decides instead. An unconditional branch is guessed taken. A conditional branch that jumps forward (non-negative offset) is guessed taken. One that jumps backward is guessed not taken. In all of these cases the target is the instruction address plus the offset. When the execution stage resolves a branch, it reports the outcome on the update port. The matching entry is trained, or allocated if there is none. A single enable input gates whether any prediction is issued.

Top module: `brpred_top`

## Requirements
- R1: A lookup presented with `lk_valid` high while `pred_en` is high produces `pred_valid` high on the following cycle only. In every cycle after one with no such lookup, `pred_valid` and `pred_taken` are low.
- R2: While `pred_en` is low, the cycle after any lookup shows `pred_valid` and `pred_taken` low. Updates received while `pred_en` is low still train the table, so later enabled lookups see that training.
- R3: On a table miss for a conditional branch (`lk_cond`=1), the guess is taken when the offset sign bit is 0 (forward, including a zero offset) and not taken when it is 1. The target is `lk_pc + lk_offset` (modulo 2^ADDR_W).
- R4: On a table miss for an unconditional branch (`lk_cond`=0), the guess is taken with target `lk_pc + lk_offset`.
- R5: A hit needs both a set valid bit and an equal tag. The index is `pc[IDX_W+1:2]` (bits [8:2] with the default 128 entries) and the tag is `pc[ADDR_W-1:IDX_W+2]`. An address sharing the index but differing in the tag is a miss.
- R6: An update that misses allocates the entry. It sets the valid bit, stores the tag and `upd_target`, and starts the state at weakly taken (code 2'b10) if `upd_taken` is 1, else at weakly not taken (code 2'b01). A later hit returns the stored target.
- R7: The direction state has four codes: 2'b00 strongly not taken, 2'b01 weakly not taken, 2'b10 weakly taken, 2'b11 strongly taken. A hit guesses taken exactly for the codes 2'b10 and 2'b11. An update that hits moves the state one code up when taken and one code down when not taken, holding at 2'b11 and 2'b00.
- R8: An update that hits replaces the stored target with `upd_target`.
- R9: When a lookup and an update address the same entry in one cycle, the lookup result reflects the entry as it was before that update.
- R10: While `rst_n` is low at a clock edge, `pred_valid` and `pred_taken` clear and every valid bit clears. Branches trained before the reset are afterwards guessed by the fixed rule.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| pred_en | input | 1 | Global prediction enable |
| lk_valid | input | 1 | Lookup request this cycle |
| lk_pc | input | ADDR_W | Instruction address of the branch being looked up |
| lk_cond | input | 1 | 1 when the looked-up branch is conditional |
| lk_offset | input | ADDR_W | Signed byte offset encoded in the branch |
| upd_valid | input | 1 | Resolved branch report this cycle |
| upd_pc | input | ADDR_W | Instruction address of the resolved branch |
| upd_taken | input | 1 | Actual direction of the resolved branch |
| upd_target | input | ADDR_W | Actual destination of the resolved branch |
| pred_valid | output | 1 | A prediction is being returned |
| pred_taken | output | 1 | Predicted direction |
| pred_target | output | ADDR_W | Predicted destination |

## Verification
The bench builds the block with 16-bit addresses and only 8 entries, so index bits [4:2] and tag bits [15:5] are narrow. That makes two nearby branch addresses collide on one index with different tags, which exercises the tag-mismatch path that a 128-entry table would push far apart. One entry is walked through every state code, including both saturation ends. The bench also collides a lookup with an update on the same index in one cycle, trains while prediction is disabled, and applies a mid-run reset to show that earlier training is forgotten.

// File: rtl/brpred_pkg.sv
// Package: brpred_pkg
// Shared types for the branch predictor. The direction state encoding is
// ordered so that a larger code means a stronger taken bias, and bit 1 alone
// gives the predicted direction.
package brpred_pkg;

    typedef enum logic [1:0] {
        DIR_SNT = 2'b00,
        DIR_WNT = 2'b01,
        DIR_WT  = 2'b10,
        DIR_ST  = 2'b11
    } dir_t;

endpackage

// File: rtl/brpred_sat_ctr.sv
// Module: brpred_sat_ctr
// Computes the next direction state for an entry being written.
// On allocation the state is seeded weakly toward the observed outcome;
// otherwise it steps one code toward the outcome and saturates at the ends.
// Assumes: pure combinational, no state of its own.
module brpred_sat_ctr
    import brpred_pkg::*;
(
    input  dir_t cur_state,
    input  logic outcome_taken,
    input  logic allocate,
    output dir_t next_state
);

    // Select seed or saturating step.
    always_comb begin
        next_state = cur_state;
        if (allocate) begin
            next_state = outcome_taken ? DIR_WT : DIR_WNT;
        end else if (outcome_taken) begin
            if (cur_state != DIR_ST) begin
                next_state = dir_t'(cur_state + 2'd1);
            end
        end else begin
            if (cur_state != DIR_SNT) begin
                next_state = dir_t'(cur_state - 2'd1);
            end
        end
    end

endmodule

// File: rtl/brpred_static.sv
// Module: brpred_static
// Fallback rule used when the history table has no entry for a branch.
// Unconditional branches are guessed taken; conditional branches are guessed
// taken when the offset is non-negative (forward) and not taken otherwise.
// The target is always the branch address plus the offset, wrapping.
// Assumes: offset is two's complement of the same width as the address.
module brpred_static #(
    parameter int ADDR_W = 32
) (
    input  logic [ADDR_W-1:0] br_pc,
    input  logic [ADDR_W-1:0] br_offset,
    input  logic              br_cond,
    output logic              guess_taken,
    output logic [ADDR_W-1:0] guess_target
);

    localparam int SIGN_BIT = ADDR_W - 1;

    // Direction from the offset sign; destination from address arithmetic.
    always_comb begin
        guess_taken  = !br_cond || !br_offset[SIGN_BIT];
        guess_target = br_pc + br_offset;
    end

endmodule

// File: rtl/brpred_store.sv
// Module: brpred_store
// Direct-mapped history storage: per entry a valid bit, tag, target and
// direction state. Two asynchronous read ports (one for lookup, one for the
// update-side hit test) and one synchronous write port.
// Assumes: reads return the contents before a write on the same edge; only
// valid bits are reset, the other fields are qualified by valid.
module brpred_store
    import brpred_pkg::*;
#(
    parameter int ADDR_W  = 32,
    parameter int ENTRIES = 128,
    parameter int IDX_W   = $clog2(ENTRIES),
    parameter int TAG_W   = ADDR_W - 2 - IDX_W
) (
    input  logic              clk,
    input  logic              rst_n,
    // lookup read port
    input  logic [IDX_W-1:0]  la_idx,
    output logic              la_valid,
    output logic [TAG_W-1:0]  la_tag,
    output logic [ADDR_W-1:0] la_target,
    output dir_t              la_state,
    // update-side read port
    input  logic [IDX_W-1:0]  ua_idx,
    output logic              ua_valid,
    output logic [TAG_W-1:0]  ua_tag,
    output dir_t              ua_state,
    // write port
    input  logic              wr_en,
    input  logic [IDX_W-1:0]  wr_idx,
    input  logic [TAG_W-1:0]  wr_tag,
    input  logic [ADDR_W-1:0] wr_target,
    input  dir_t              wr_state
);

    logic [ENTRIES-1:0] valid_vec;
    logic [TAG_W-1:0]   tag_mem    [ENTRIES];
    logic [ADDR_W-1:0]  target_mem [ENTRIES];
    dir_t               state_mem  [ENTRIES];

    // One valid flop per entry, each with its own set condition.
    for (genvar e = 0; e < ENTRIES; e++) begin : g_valid
        logic v_q;
        // Clear on reset, set when this entry is written.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                v_q <= 1'b0;
            end else if (wr_en && (wr_idx == IDX_W'(e))) begin
                v_q <= 1'b1;
            end
        end
        assign valid_vec[e] = v_q;
    end

    // Payload fields: written on any update, never reset.
    always_ff @(posedge clk) begin
        if (wr_en) begin
            tag_mem[wr_idx]    <= wr_tag;
            target_mem[wr_idx] <= wr_target;
            state_mem[wr_idx]  <= wr_state;
        end
    end

    // Lookup read port.
    always_comb begin
        la_valid  = valid_vec[la_idx];
        la_tag    = tag_mem[la_idx];
        la_target = target_mem[la_idx];
        la_state  = state_mem[la_idx];
    end

    // Update-side read port.
    always_comb begin
        ua_valid = valid_vec[ua_idx];
        ua_tag   = tag_mem[ua_idx];
        ua_state = state_mem[ua_idx];
    end

endmodule

// File: rtl/brpred_top.sv
// Module: brpred_top
// Branch direction and target predictor for relative branches.
// A lookup is answered one cycle later from the history table on a hit, or
// from the fixed direction rule on a miss. Resolved branches train or
// allocate their entry. The enable only gates issuing predictions; training
// continues while it is low.
// Assumes: instructions are word aligned (pc[1:0] ignored); a lookup and an
// update on the same entry in one cycle sees the pre-update entry.
module brpred_top
    import brpred_pkg::*;
#(
    parameter int ADDR_W  = 32,
    parameter int ENTRIES = 128
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              pred_en,
    input  logic              lk_valid,
    input  logic [ADDR_W-1:0] lk_pc,
    input  logic              lk_cond,
    input  logic [ADDR_W-1:0] lk_offset,
    input  logic              upd_valid,
    input  logic [ADDR_W-1:0] upd_pc,
    input  logic              upd_taken,
    input  logic [ADDR_W-1:0] upd_target,
    output logic              pred_valid,
    output logic              pred_taken,
    output logic [ADDR_W-1:0] pred_target
);

    localparam int IDX_W  = $clog2(ENTRIES);
    localparam int TAG_W  = ADDR_W - 2 - IDX_W;
    localparam int IDX_LO = 2;
    localparam int IDX_HI = IDX_LO + IDX_W - 1;
    localparam int TAG_LO = IDX_HI + 1;

    logic [IDX_W-1:0]  lk_idx, up_idx;
    logic [TAG_W-1:0]  lk_tag, up_tag;
    logic              la_valid, ua_valid;
    logic [TAG_W-1:0]  la_tag, ua_tag;
    logic [ADDR_W-1:0] la_target;
    dir_t              la_state, ua_state, wr_state;
    logic              lk_hit, up_hit;
    logic              st_taken;
    logic [ADDR_W-1:0] st_target;
    logic              nx_taken;
    logic [ADDR_W-1:0] nx_target;
    logic              issue;
    logic              unused_low_bits;

    // Split addresses into index and tag fields.
    always_comb begin
        lk_idx = lk_pc[IDX_HI:IDX_LO];
        lk_tag = lk_pc[ADDR_W-1:TAG_LO];
        up_idx = upd_pc[IDX_HI:IDX_LO];
        up_tag = upd_pc[ADDR_W-1:TAG_LO];
    end

    assign unused_low_bits = ^{lk_pc[IDX_LO-1:0], upd_pc[IDX_LO-1:0]};

    brpred_store #(
        .ADDR_W  (ADDR_W),
        .ENTRIES (ENTRIES),
        .IDX_W   (IDX_W),
        .TAG_W   (TAG_W)
    ) u_store (
        .clk       (clk),
        .rst_n     (rst_n),
        .la_idx    (lk_idx),
        .la_valid  (la_valid),
        .la_tag    (la_tag),
        .la_target (la_target),
        .la_state  (la_state),
        .ua_idx    (up_idx),
        .ua_valid  (ua_valid),
        .ua_tag    (ua_tag),
        .ua_state  (ua_state),
        .wr_en     (upd_valid),
        .wr_idx    (up_idx),
        .wr_tag    (up_tag),
        .wr_target (upd_target),
        .wr_state  (wr_state)
    );

    // Hit tests on both read ports.
    always_comb begin
        lk_hit = la_valid && (la_tag == lk_tag);
        up_hit = ua_valid && (ua_tag == up_tag);
    end

    brpred_sat_ctr u_ctr (
        .cur_state     (ua_state),
        .outcome_taken (upd_taken),
        .allocate      (!up_hit),
        .next_state    (wr_state)
    );

    brpred_static #(
        .ADDR_W (ADDR_W)
    ) u_static (
        .br_pc        (lk_pc),
        .br_offset    (lk_offset),
        .br_cond      (lk_cond),
        .guess_taken  (st_taken),
        .guess_target (st_target)
    );

    // Choose between table and fixed rule.
    always_comb begin
        issue     = lk_valid && pred_en;
        nx_taken  = lk_hit ? la_state[1] : st_taken;
        nx_target = lk_hit ? la_target : st_target;
    end

    // Register the prediction; direction forced low when nothing is issued.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pred_valid  <= 1'b0;
            pred_taken  <= 1'b0;
            pred_target <= '0;
        end else begin
            pred_valid <= issue;
            pred_taken <= issue && nx_taken;
            if (issue) begin
                pred_target <= nx_target;
            end
        end
    end

endmodule

// File: rtl/brpred_chk.sv
// Module: brpred_chk
// Assertion checker bound into brpred_top. Relates the lookup port and the
// table hit indication to the registered prediction one cycle later.
module brpred_chk #(
    parameter int ADDR_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              pred_en,
    input logic              lk_valid,
    input logic              lk_cond,
    input logic [ADDR_W-1:0] lk_pc,
    input logic [ADDR_W-1:0] lk_offset,
    input logic              lk_hit,
    input logic              pred_valid,
    input logic              pred_taken,
    input logic [ADDR_W-1:0] pred_target
);

    logic [ADDR_W-1:0] fall_sum;
    assign fall_sum = lk_pc + lk_offset;

    // R1: an enabled lookup yields a prediction next cycle.
    a_r1_issue_next: assert property (@(posedge clk) disable iff (!rst_n)
        (lk_valid && pred_en) |=> pred_valid);

    // R1: without an enabled lookup the outputs stay quiet next cycle.
    a_r1_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !(lk_valid && pred_en) |=> (!pred_valid && !pred_taken));

    // R2: disabled means no prediction.
    a_r2_disabled: assert property (@(posedge clk) disable iff (!rst_n)
        !pred_en |=> (!pred_valid && !pred_taken));

    // R3: conditional miss follows offset sign, target is pc plus offset.
    a_r3_cond_miss: assert property (@(posedge clk) disable iff (!rst_n)
        (lk_valid && pred_en && lk_cond && !lk_hit) |=>
        ((pred_taken == !$past(lk_offset[ADDR_W-1])) && (pred_target == $past(fall_sum))));

    // R4: unconditional miss is taken to pc plus offset.
    a_r4_uncond_miss: assert property (@(posedge clk) disable iff (!rst_n)
        (lk_valid && pred_en && !lk_cond && !lk_hit) |=>
        (pred_taken && (pred_target == $past(fall_sum))));

endmodule

bind brpred_top brpred_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .pred_en     (pred_en),
    .lk_valid    (lk_valid),
    .lk_cond     (lk_cond),
    .lk_pc       (lk_pc),
    .lk_offset   (lk_offset),
    .lk_hit      (lk_hit),
    .pred_valid  (pred_valid),
    .pred_taken  (pred_taken),
    .pred_target (pred_target)
);

// File: tb/tb_brpred_top.sv
// Scoreboard bench: the driver pushes one expected item per driven cycle,
// the monitor pops and compares it one clock later.
module tb_brpred_top;

    localparam int AW = 16;
    localparam int NE = 8;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          pred_en = 1'b0;
    logic          lk_valid = 1'b0;
    logic [AW-1:0] lk_pc = '0;
    logic          lk_cond = 1'b0;
    logic [AW-1:0] lk_offset = '0;
    logic          upd_valid = 1'b0;
    logic [AW-1:0] upd_pc = '0;
    logic          upd_taken = 1'b0;
    logic [AW-1:0] upd_target = '0;
    logic          pred_valid;
    logic          pred_taken;
    logic [AW-1:0] pred_target;

    int n_chk = 0;
    int n_fail = 0;

    typedef struct {
        logic          v;
        logic          t;
        logic [AW-1:0] tg;
        string         req;
    } exp_item_t;

    exp_item_t sb_q[$];

    always #2 clk = ~clk;

    brpred_top #(.ADDR_W(AW), .ENTRIES(NE)) dut (
        .clk(clk), .rst_n(rst_n), .pred_en(pred_en),
        .lk_valid(lk_valid), .lk_pc(lk_pc), .lk_cond(lk_cond), .lk_offset(lk_offset),
        .upd_valid(upd_valid), .upd_pc(upd_pc), .upd_taken(upd_taken), .upd_target(upd_target),
        .pred_valid(pred_valid), .pred_taken(pred_taken), .pred_target(pred_target)
    );

    task automatic check(input bit ok, input string req, input string what,
                         input logic [AW-1:0] act, input logic [AW-1:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    task automatic drive(input bit lv, input bit en, input logic [AW-1:0] pc,
                         input bit cond, input logic [AW-1:0] off,
                         input bit uv, input logic [AW-1:0] upc, input bit ut,
                         input logic [AW-1:0] utg,
                         input bit ev, input bit et, input logic [AW-1:0] etg,
                         input string req);
        exp_item_t it;
        @(negedge clk);
        lk_valid = lv; pred_en = en; lk_pc = pc; lk_cond = cond; lk_offset = off;
        upd_valid = uv; upd_pc = upc; upd_taken = ut; upd_target = utg;
        it.v = ev; it.t = et; it.tg = etg; it.req = req;
        sb_q.push_back(it);
    endtask

    task automatic look(input logic [AW-1:0] pc, input bit cond, input logic [AW-1:0] off,
                        input bit et, input logic [AW-1:0] etg, input string req);
        drive(1, 1, pc, cond, off, 0, '0, 0, '0, 1, et, etg, req);
    endtask

    task automatic train(input logic [AW-1:0] pc, input bit t, input logic [AW-1:0] tg,
                         input bit en, input string req);
        drive(0, en, '0, 0, '0, 1, pc, t, tg, 0, 0, '0, req);
    endtask

    task automatic idle(input string req);
        drive(0, 1, '0, 0, '0, 0, '0, 0, '0, 0, 0, '0, req);
    endtask

    // Monitor: compare one item per clock just after the edge.
    initial begin
        forever begin
            @(posedge clk);
            #1;
            if (rst_n && sb_q.size() > 0) begin
                exp_item_t e;
                e = sb_q.pop_front();
                if (e.v) begin
                    check(pred_valid == 1'b1, e.req, "pred_valid", AW'(pred_valid), AW'(1));
                    check(pred_taken == e.t, e.req, "pred_taken", AW'(pred_taken), AW'(e.t));
                    check(pred_target == e.tg, e.req, "pred_target", pred_target, e.tg);
                end else begin
                    check(!pred_valid && !pred_taken, e.req, "quiet valid/taken",
                          AW'({pred_valid, pred_taken}), AW'(0));
                end
            end
        end
    end

    // Watchdog.
    initial begin
        repeat (20000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog actual=hung expected=finished");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    task automatic drain();
        idle("R1");
        while (sb_q.size() > 0) @(negedge clk);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        check(!pred_valid && !pred_taken, "R10", "reset outputs",
              AW'({pred_valid, pred_taken}), AW'(0));
        rst_n = 1'b1;

        // R3 / R4: misses use the fixed rule.
        look(16'h0100, 1, 16'h0020, 1, 16'h0120, "R3 forward");
        look(16'h0104, 1, 16'hFFF0, 0, 16'h00F4, "R3 backward");
        look(16'h0108, 1, 16'h0000, 1, 16'h0108, "R3 zero offset");
        look(16'h010C, 0, 16'hFFC0, 1, 16'h00CC, "R4 uncond backward");
        idle("R1 idle");

        // R6: allocation seeds weakly toward outcome and stores target.
        train(16'h0104, 1, 16'h0300, 1, "R6");
        look(16'h0104, 1, 16'hFFF0, 1, 16'h0300, "R6 alloc taken");
        train(16'h0100, 0, 16'h0200, 1, "R6");
        look(16'h0100, 1, 16'h0020, 0, 16'h0200, "R6 alloc not taken");

        // R7: walk the states of 0x0104 (now weakly taken).
        train(16'h0104, 0, 16'h0300, 1, "R7");
        look(16'h0104, 1, 16'hFFF0, 0, 16'h0300, "R7 WT->WNT");
        train(16'h0104, 0, 16'h0300, 1, "R7");
        look(16'h0104, 1, 16'hFFF0, 0, 16'h0300, "R7 WNT->SNT");
        train(16'h0104, 0, 16'h0300, 1, "R7");
        train(16'h0104, 1, 16'h0300, 1, "R7");
        look(16'h0104, 1, 16'hFFF0, 0, 16'h0300, "R7 SNT sat then up to WNT");
        train(16'h0104, 1, 16'h0300, 1, "R7");
        look(16'h0104, 1, 16'hFFF0, 1, 16'h0300, "R7 WNT->WT");
        train(16'h0104, 1, 16'h0300, 1, "R7");
        train(16'h0104, 1, 16'h0300, 1, "R7");
        train(16'h0104, 0, 16'h0300, 1, "R7");
        look(16'h0104, 1, 16'hFFF0, 1, 16'h0300, "R7 ST sat then down to WT");

        // R8: hit update replaces target (WT -> ST).
        train(16'h0104, 1, 16'h0400, 1, "R8");
        look(16'h0104, 1, 16'hFFF0, 1, 16'h0400, "R8 new target");

        // R5: same index (1), different tag, misses.
        look(16'h0124, 1, 16'hFFF8, 0, 16'h011C, "R5 tag mismatch");
        look(16'h0124, 0, 16'hFFF8, 1, 16'h011C, "R5 tag mismatch uncond");

        // R9: same-cycle lookup and update see the old entry (0x0100 WNT).
        drive(1, 1, 16'h0100, 1, 16'h0020, 1, 16'h0100, 1, 16'h0500,
              1, 0, 16'h0200, "R9 old state");
        look(16'h0100, 1, 16'h0020, 1, 16'h0500, "R9 after update");

        // R2: disabled lookups are silent; training continues.
        drive(1, 0, 16'h0104, 1, 16'hFFF0, 0, '0, 0, '0, 0, 0, '0, "R2 disabled lookup");
        train(16'h0108, 1, 16'h0600, 0, "R2 train while disabled");
        look(16'h0108, 1, 16'hFFFC, 1, 16'h0600, "R2 training kept");
        drain();

        // R10: mid-run reset forgets training.
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        @(negedge clk);
        check(!pred_valid && !pred_taken, "R10", "mid-run reset outputs",
              AW'({pred_valid, pred_taken}), AW'(0));
        rst_n = 1'b1;
        look(16'h0104, 1, 16'hFFF0, 0, 16'h00F4, "R10 entry cleared");
        look(16'h0108, 1, 16'hFFFC, 0, 16'h0104, "R10 entry cleared 2");
        drain();

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule